// File: doc/BRIEF.md
# Serial Adapter Host Register Sequencer

This block is the host-side control front end of a programmable asynchronous serial adapter. A host reaches two byte-wide ports through a chip select and one address line. Address 0 is the data port: reads return the last received character and writes hand a character to the transmitter. Address 1 is the control port: reads return a status byte and writes carry configuration.

Control writes follow a two-phase sequence. The first control write after reset is taken as the line-format (mode) word. Every later control write is a command word. A command with its internal-reset bit set puts the block back into the mode-word phase with everything cleared. The block drives the line-format fields and the transmit and receive enables to the shifting and baud blocks. It also keeps the status flags that those blocks report and merges them into the status byte.

Top module: `usart_ctl`

## Requirements
- R1: `rdata` is 0 unless `cs` and `rd` are both high. A read at `addr`=1 returns the status byte and a read at `addr`=0 returns the receive buffer. Writes with `cs` low change nothing.
- R2: The first control write (`cs`, `wr`, `addr`=1) after reset loads the mode register. Each later control write loads the command register and leaves the mode register unchanged.
- R3: Mode word fields drive the outputs directly: bits 1:0 drive `baud_sel`, bits 3:2 drive `char_len`, bit 4 drives `par_en`, bit 5 drives `par_even` and bits 7:6 drive `stop_sel`.
- R4: Command bit 0 enables transmit and bit 2 enables receive. Bit 3 drives `brk`. Bit 1 drives `dtr_n` low and bit 5 drives `rts_n` low. Bit 7 (hunt) has no effect on any output.
- R5: A command with bit 6 set returns the block to its reset state from the next cycle: mode and command registers cleared, status 0x05 with `dsr_n` high, receive buffer 0. The next control write is then taken as a mode word.
- R6: Status byte layout: bit0 transmitter ready, bit1 receive ready, bit2 transmitter empty, bit3 parity error, bit4 overrun, bit5 framing error, bit6 always 0, bit7 the inverse of `dsr_n`. After reset it reads 0x05 with `dsr_n` high.
- R7: `rx_valid` latches `rx_char` into the receive buffer and sets receive ready. A data-port read clears receive ready in the next cycle. If both happen in the same cycle, receive ready stays set.
- R8: `rx_valid` while receive ready is set and no data-port read happens in the same cycle sets the sticky overrun flag. The new character replaces the old one.
- R9: `rx_par_err` and `rx_frm_err` pulses set sticky flags. A command with bit 4 set clears parity, overrun and framing flags from the next cycle, and a set in the same cycle loses. Bit 4 is not stored, so later errors set the flags again.
- R10: `tx_en` and `rx_en` are high only when the command bit is set and a mode word with a nonzero baud field is loaded. While a mode word with baud field 00 is loaded, `bad_mode` is 1 and both enables stay 0.
- R11: A data-port write pulses `tx_load` with `tx_data`=`wdata` in the same cycle and clears transmitter ready and transmitter empty. `tx_took` sets transmitter ready again and `tx_drained` sets transmitter empty. If a data write and a set arrive in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| addr | input | 1 | Port select: 0 data, 1 control/status |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| rx_valid | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Received character |
| rx_par_err | input | 1 | Receiver parity error pulse |
| rx_frm_err | input | 1 | Receiver framing error pulse |
| tx_took | input | 1 | Transmitter accepted the held character |
| tx_drained | input | 1 | Transmitter finished shifting out |
| dsr_n | input | 1 | Data-set-ready line, active low |
| tx_load | output | 1 | Character handed to the transmitter |
| tx_data | output | 8 | Character for the transmitter |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| brk | output | 1 | Force line to break |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| baud_sel | output | 2 | Baud factor field |
| char_len | output | 2 | Character length field |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| stop_sel | output | 2 | Stop-bit field |
| bad_mode | output | 1 | Loaded mode word has baud field 00 |

## Verification
The bench targets the phase sequence. If the sequencer stayed in mode phase, the command write would overwrite the baud field. If it never returned after an internal reset, the following mode word would be read as a command. It checks the same-cycle collisions: a character arriving during a buffer read must not raise overrun, an error clear must beat a simultaneous parity error, and a data write must beat a transmitter-took pulse. A design that kept the error-reset bit as a level would fail to show the parity error raised after the clear. The bench also loads a synchronous-baud mode and checks that enabling commands leave both enables low, and that hunt-only and deselected writes change no output.

// File: rtl/usart_ctl_pkg.sv
package usart_ctl_pkg;
    localparam int unsigned BYTE_W = 8;

    // line-format word, packed high bit first so it casts from the host byte
    typedef struct packed {
        logic [1:0] stop;
        logic       par_even;
        logic       par_en;
        logic [1:0] len;
        logic [1:0] baud;
    } mode_t;

    // command bits that persist as levels (error-reset and internal reset act once)
    typedef struct packed {
        logic rts;
        logic brk;
        logic rx_en;
        logic dtr;
        logic tx_en;
    } cmd_t;

    localparam int unsigned C_TXEN = 0;
    localparam int unsigned C_DTR  = 1;
    localparam int unsigned C_RXEN = 2;
    localparam int unsigned C_BRK  = 3;
    localparam int unsigned C_ERST = 4;
    localparam int unsigned C_RTS  = 5;
    localparam int unsigned C_SRST = 6;

    typedef struct packed {
        logic               txrdy;
        logic               rxrdy;
        logic               txempty;
        logic               pe;
        logic               oe;
        logic               fe;
        logic [BYTE_W-1:0]  rxbuf;
    } flags_t;
endpackage

// File: rtl/usart_ctl_seq.sv
module usart_ctl_seq
    import usart_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] wdata,
    output mode_t             mode_o,
    output cmd_t              cmd_o,
    output logic              cmd_phase,
    output logic              err_clr,
    output logic              soft_rst
);
    typedef struct packed {
        mode_t mode;
        cmd_t  cmd;
        logic  phase;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d        = q;
        err_clr  = 1'b0;
        soft_rst = 1'b0;
        if (ctl_wr) begin
            if (!q.phase) begin
                d.mode  = mode_t'(wdata);
                d.phase = 1'b1;
            end else if (wdata[C_SRST]) begin
                soft_rst = 1'b1;
                d        = '0;
            end else begin
                d.cmd.tx_en = wdata[C_TXEN];
                d.cmd.dtr   = wdata[C_DTR];
                d.cmd.rx_en = wdata[C_RXEN];
                d.cmd.brk   = wdata[C_BRK];
                d.cmd.rts   = wdata[C_RTS];
                err_clr     = wdata[C_ERST];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode_o    = q.mode;
    assign cmd_o     = q.cmd;
    assign cmd_phase = q.phase;

    AST_MODE_THEN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !q.phase |=> q.phase && (q.mode == mode_t'($past(wdata)))); // R2
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && q.phase && wdata[C_SRST] |=> !q.phase && (q.mode == '0) && (q.cmd == '0)); // R5
endmodule

// File: rtl/usart_ctl_stat.sv
module usart_ctl_stat
    import usart_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              err_clr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_char,
    input  logic              pe_set,
    input  logic              fe_set,
    input  logic              tx_took,
    input  logic              tx_drained,
    output flags_t            flags
);
    localparam flags_t FLAGS_RST = '{txrdy: 1'b1, rxrdy: 1'b0, txempty: 1'b1,
                                     pe: 1'b0, oe: 1'b0, fe: 1'b0, rxbuf: '0};

    flags_t d, q;

    always_comb begin
        d = q;
        if (tx_took)    d.txrdy   = 1'b1;
        if (tx_drained) d.txempty = 1'b1;
        if (data_wr) begin
            d.txrdy   = 1'b0;
            d.txempty = 1'b0;
        end
        if (data_rd) d.rxrdy = 1'b0;
        if (rx_valid) begin
            d.rxbuf = rx_char;
            d.rxrdy = 1'b1;
            if (q.rxrdy && !data_rd) d.oe = 1'b1;
        end
        if (pe_set) d.pe = 1'b1;
        if (fe_set) d.fe = 1'b1;
        if (err_clr) begin
            d.pe = 1'b0;
            d.oe = 1'b0;
            d.fe = 1'b0;
        end
        if (soft_rst) d = FLAGS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FLAGS_RST;
        else        q <= d;
    end

    assign flags = q;

    AST_RX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !rx_valid |=> !q.rxrdy); // R7
    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && q.rxrdy && !data_rd && !soft_rst && !err_clr |=> q.oe); // R8
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !q.pe && !q.oe && !q.fe); // R9
    AST_TX_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !q.txrdy && !q.txempty); // R11
endmodule

// File: rtl/usart_ctl.sv
module usart_ctl
    import usart_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_char,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              tx_took,
    input  logic              tx_drained,
    input  logic              dsr_n,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_en,
    output logic              rx_en,
    output logic              brk,
    output logic              dtr_n,
    output logic              rts_n,
    output logic [1:0]        baud_sel,
    output logic [1:0]        char_len,
    output logic              par_en,
    output logic              par_even,
    output logic [1:0]        stop_sel,
    output logic              bad_mode
);
    logic   ctl_wr, data_wr, data_rd;
    logic   cmd_phase, err_clr, soft_rst, mode_ok;
    mode_t  mode;
    cmd_t   cmd;
    flags_t flags;
    logic [BYTE_W-1:0] status;

    assign ctl_wr  = cs && wr &&  addr;
    assign data_wr = cs && wr && !addr;
    assign data_rd = cs && rd && !addr;

    usart_ctl_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(wdata),
        .mode_o(mode), .cmd_o(cmd), .cmd_phase(cmd_phase),
        .err_clr(err_clr), .soft_rst(soft_rst)
    );

    usart_ctl_stat u_stat (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .err_clr(err_clr),
        .data_rd(data_rd), .data_wr(data_wr), .rx_valid(rx_valid),
        .rx_char(rx_char), .pe_set(rx_par_err), .fe_set(rx_frm_err),
        .tx_took(tx_took), .tx_drained(tx_drained), .flags(flags)
    );

    assign mode_ok  = cmd_phase && (mode.baud != 2'b00);
    assign bad_mode = cmd_phase && (mode.baud == 2'b00);

    assign status = {~dsr_n, 1'b0, flags.fe, flags.oe, flags.pe,
                     flags.txempty, flags.rxrdy, flags.txrdy};

    always_comb begin
        rdata = '0;
        if (cs && rd) rdata = addr ? status : flags.rxbuf;
    end

    assign tx_load  = data_wr;
    assign tx_data  = data_wr ? wdata : '0;
    assign tx_en    = cmd.tx_en && mode_ok;
    assign rx_en    = cmd.rx_en && mode_ok;
    assign brk      = cmd.brk;
    assign dtr_n    = ~cmd.dtr;
    assign rts_n    = ~cmd.rts;
    assign baud_sel = mode.baud;
    assign char_len = mode.len;
    assign par_en   = mode.par_en;
    assign par_even = mode.par_even;
    assign stop_sel = mode.stop;

    AST_BAD_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |-> !tx_en && !rx_en); // R10
endmodule

// File: tb/sim_usart_ctl.sv
module sim_usart_ctl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cs, addr, rd, wr, rx_valid, rx_par_err, rx_frm_err;
    logic tx_took, tx_drained, dsr_n;
    logic [7:0] wdata, rx_char, rdata, tx_data;
    logic tx_load, tx_en, rx_en, brk, dtr_n, rts_n, par_en, par_even, bad_mode;
    logic [1:0] baud_sel, char_len, stop_sel;

    usart_ctl u0 (.*);

    int errs = 0, checks = 0;
    bit m_phase, m_txr, m_txe, m_rxr, m_pe, m_oe, m_fe;
    logic [7:0] m_mode, m_cmd, m_rxb;

    task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_mode = 0; m_cmd = 0; m_rxb = 0;
        m_txr = 1; m_txe = 1; m_rxr = 0; m_pe = 0; m_oe = 0; m_fe = 0;
    endtask

    function automatic logic [7:0] m_status();
        return {~dsr_n, 1'b0, m_fe, m_oe, m_pe, m_txe, m_rxr, m_txr};
    endfunction

    task automatic compare(string tag);
        bit ok;
        logic [7:0] er;
        ok = m_phase && (m_mode[1:0] != 0);
        er = (cs && rd) ? (addr ? m_status() : m_rxb) : 8'h00;
        chk(tag, "rdata", rdata, er);
        chk("R3", "mode fields", {stop_sel, par_even, par_en, char_len, baud_sel}, m_mode);
        chk("R4", "line controls", {5'b0, brk, dtr_n, rts_n}, {5'b0, m_cmd[3], ~m_cmd[1], ~m_cmd[5]});
        chk("R10", "enables", {6'b0, tx_en, rx_en}, {6'b0, m_cmd[0] & ok, m_cmd[2] & ok});
        chk("R10", "bad_mode", {7'b0, bad_mode}, {7'b0, m_phase && m_mode[1:0] == 0});
        chk("R11", "tx_load", {7'b0, tx_load}, {7'b0, cs && wr && !addr});
        chk("R11", "tx_data", tx_data, (cs && wr && !addr) ? wdata : 8'h00);
    endtask

    task automatic model_update();
        bit ctl, dwr, drd, srst, eclr, old_rxr;
        ctl = cs && wr && addr; dwr = cs && wr && !addr; drd = cs && rd && !addr;
        srst = 0; eclr = 0; old_rxr = m_rxr;
        if (ctl) begin
            if (!m_phase) begin m_mode = wdata; m_phase = 1; end
            else if (wdata[6]) srst = 1;
            else begin m_cmd = wdata & 8'h2F; eclr = wdata[4]; end
        end
        if (tx_took) m_txr = 1;
        if (tx_drained) m_txe = 1;
        if (dwr) begin m_txr = 0; m_txe = 0; end
        if (drd) m_rxr = 0;
        if (rx_valid) begin
            m_rxb = rx_char; m_rxr = 1;
            if (old_rxr && !drd) m_oe = 1;
        end
        if (rx_par_err) m_pe = 1;
        if (rx_frm_err) m_fe = 1;
        if (eclr) begin m_pe = 0; m_oe = 0; m_fe = 0; end
        if (srst) model_reset();
    endtask

    task automatic clear_in();
        cs = 0; addr = 0; rd = 0; wr = 0; wdata = 0; rx_valid = 0; rx_char = 0;
        rx_par_err = 0; rx_frm_err = 0; tx_took = 0; tx_drained = 0;
    endtask

    task automatic cyc(string tag);
        #1 compare(tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        clear_in();
    endtask

    task automatic wr_ctl(logic [7:0] v, string tag);
        cs = 1; addr = 1; wr = 1; wdata = v; cyc(tag);
    endtask
    task automatic wr_dat(logic [7:0] v, string tag);
        cs = 1; addr = 0; wr = 1; wdata = v; cyc(tag);
    endtask
    task automatic rd_stat(logic [7:0] exp, string tag);
        cs = 1; addr = 1; rd = 1; #1 chk(tag, "status literal", rdata, exp); cyc(tag);
    endtask
    task automatic rd_dat(logic [7:0] exp, string tag);
        cs = 1; addr = 0; rd = 1; #1 chk(tag, "data literal", rdata, exp); cyc(tag);
    endtask
    task automatic rx(logic [7:0] c, string tag);
        rx_valid = 1; rx_char = c; cyc(tag);
    endtask

    initial begin
        #(20 * 200000);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        clear_in(); dsr_n = 1; rst_n = 0; model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc("R6");
        rd_stat(8'h05, "R6");
        rd_dat(8'h00, "R1");
        dsr_n = 0;
        rd_stat(8'h85, "R6");
        // R2: mode then command
        wr_ctl(8'hCE, "R2");
        chk("R3", "baud after mode", {6'b0, baud_sel}, 8'h02);
        wr_ctl(8'h27, "R2");
        chk("R2", "mode kept after command", {stop_sel, par_even, par_en, char_len, baud_sel}, 8'hCE);
        chk("R4", "enables on", {6'b0, tx_en, rx_en}, 8'h03);
        wr_ctl(8'h08, "R4");
        chk("R4", "break", {7'b0, brk}, 8'h01);
        wr_ctl(8'h80, "R4");
        chk("R4", "hunt only", {4'b0, brk, dtr_n, rts_n, tx_en}, 8'h06);
        wr_ctl(8'h05, "R4");
        // R7 receive path
        rx(8'h41, "R7");
        rd_stat(8'h87, "R7");
        rd_dat(8'h41, "R7");
        rd_stat(8'h85, "R7");
        // R8 overrun
        rx(8'h11, "R8"); rx(8'h22, "R8");
        rd_stat(8'h97, "R8");
        rd_dat(8'h22, "R8");
        wr_ctl(8'h15, "R9");
        rx(8'h31, "R7");
        cs = 1; addr = 0; rd = 1; rx_valid = 1; rx_char = 8'h33; cyc("R7");
        rd_stat(8'h87, "R8");
        rd_dat(8'h33, "R7");
        // R9 error flags
        rx_par_err = 1; rx_frm_err = 1; cyc("R9");
        rd_stat(8'hAD, "R9");
        wr_ctl(8'h15, "R9");
        rd_stat(8'h85, "R9");
        chk("R9", "tx_en kept", {7'b0, tx_en}, 8'h01);
        rx_par_err = 1; cyc("R9");
        rd_stat(8'h8D, "R9");
        cs = 1; addr = 1; wr = 1; wdata = 8'h15; rx_par_err = 1; cyc("R9");
        rd_stat(8'h85, "R9");
        // R11 transmit handoff
        wr_dat(8'h5A, "R11");
        rd_stat(8'h80, "R11");
        cs = 1; addr = 0; wr = 1; wdata = 8'hA5; tx_took = 1; cyc("R11");
        rd_stat(8'h80, "R11");
        tx_took = 1; cyc("R11");
        rd_stat(8'h81, "R11");
        tx_drained = 1; cyc("R11");
        rd_stat(8'h85, "R11");
        // R1 deselected write ignored
        addr = 1; wr = 1; wdata = 8'h40; cyc("R1");
        chk("R1", "tx_en after deselected write", {7'b0, tx_en}, 8'h01);
        // R5 internal reset and R10 synchronous mode
        rx(8'h77, "R5");
        wr_ctl(8'h40, "R5");
        rd_stat(8'h85, "R5");
        rd_dat(8'h00, "R5");
        wr_ctl(8'h00, "R10");
        chk("R10", "bad_mode", {7'b0, bad_mode}, 8'h01);
        wr_ctl(8'h05, "R10");
        chk("R10", "enables held off", {6'b0, tx_en, rx_en}, 8'h00);
        wr_ctl(8'h40, "R5");
        wr_ctl(8'h4D, "R5");
        chk("R5", "mode after reset", {stop_sel, par_even, par_en, char_len, baud_sel}, 8'h4D);
        wr_ctl(8'h01, "R5");
        chk("R5", "tx_en after remode", {6'b0, tx_en, rx_en}, 8'h02);
        cyc("R1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule